// File: doc/BRIEF.md
# External Memory Port Controller

This block owns the single external memory expansion port of a processor core with a 16-bit address and a 24-bit data word. The core asks for one access at a time. Each request names a space (program, X data, Y data or exception vector), a direction, an address and, for a write, the data. The controller drives the address and data pins, a three-signal space select, separate active-low read and write strobes, and an early bus strobe. It adds wait states for as long as an external device holds the wait input low. Tri-state is modelled with three output enables: one for the address bus, one for the data bus and one for the control group.

A second bus master can take the port by pulling the request input low. The controller gives the port up only when the core signals an instruction boundary and no access is in flight. It then floats every pin and asserts grant. If the core needs the bus while it does not own it, the core is stalled and the bus-needed output stays asserted, so that an arbiter can decide when to return the port. When the request is withdrawn, grant drops and the controller spends one turnaround cycle with the port still floating before it drives again.

The machine has six states. ST_IDLE drives the idle select code. ST_STROBE is the first cycle of an access, with the bus strobe low. ST_WAIT holds the access while wait is seen. ST_FINISH is the last access cycle, with the bus strobe high and read data captured. ST_RELEASED floats the port and grants it. ST_RECLAIM is the turnaround cycle. The transitions are:
- IDLE to RELEASED when a request is seen at a boundary.
- IDLE to STROBE when the core asks for an access.
- STROBE or WAIT to WAIT while wait is seen, otherwise to FINISH.
- FINISH to IDLE.
- RELEASED to RECLAIM when the request is withdrawn.
- RECLAIM to IDLE.

Top module: `ext_port_ctrl`

## Requirements
- R1: The select outputs {ps_n, ds_n, xy_sel} read 111 when no access is running, 011 for a program access (core_space 0), 101 for X data (core_space 1) and 100 for Y data (core_space 2). While ctl_oe is high they never show 00x or 110.
- R2: A vector access (core_space 3) drives 010 when dev_mode was high at the start of the access. Otherwise it drives the program code 011.
- R3: addr_o changes only when an access starts, and it keeps its last value on cycles with no access.
- R4: Release happens only from ST_IDLE, with core_at_boundary high and the synchronized request active. An access in progress is always completed first. While the port is released, addr_oe, data_oe and ctl_oe are all low.
- R5: bg_n goes low in the cycle after release and stays low while the request is held. After the request is withdrawn, bg_n rises while ctl_oe is still low for one cycle, and the port is driven again in the following cycle.
- R6: bn_n is the inverse of core_req outside reset. core_stall is high while core_req is high and core_ack is low. This keeps the core stalled for as long as another master holds the port.
- R7: An access with no wait lasts two cycles: ST_STROBE with bs_n low, then ST_FINISH with bs_n high and core_ack high. Each cycle in which the synchronized wait is seen while bs_n is low adds one more cycle with bs_n low.
- R8: While rst_n is low, the outputs are addr_oe=0, data_oe=0, ctl_oe=0, bg_n=1, bs_n=1 and bn_n=1.
- R9: data_oe is high only during write accesses on an owned bus, and data_o then carries the write data. Read data is taken from data_i on the ST_FINISH cycle and appears on core_rdata in the next cycle.
- R10: rd_n and wr_n are never low together. br_n and wait_n act through a two-flop synchronizer, so they take effect two clocks after they change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_req | input | 1 | Core asks for an external access; held until core_ack |
| core_space | input | 2 | 0 program, 1 X data, 2 Y data, 3 vector |
| core_wr | input | 1 | 1 write, 0 read |
| core_addr | input | 16 | Access address |
| core_wdata | input | 24 | Write data |
| core_at_boundary | input | 1 | Current instruction has completed |
| dev_mode | input | 1 | Development mode allows the vector select code |
| core_ack | output | 1 | Last cycle of the access |
| core_stall | output | 1 | Core must hold in wait states |
| core_rdata | output | 24 | Captured read data |
| addr_o | output | 16 | Address pins |
| addr_oe | output | 1 | Address bus drive enable |
| data_o | output | 24 | Data pins, outgoing |
| data_i | input | 24 | Data pins, incoming |
| data_oe | output | 1 | Data bus drive enable |
| ps_n | output | 1 | Program space select, active low |
| ds_n | output | 1 | Data space select, active low |
| xy_sel | output | 1 | 1 X space, 0 Y space |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| bs_n | output | 1 | Early bus strobe, active low |
| ctl_oe | output | 1 | Drive enable for select, strobes and bus strobe |
| br_n | input | 1 | Bus request from another master, active low |
| bg_n | output | 1 | Bus grant, active low |
| wait_n | input | 1 | Wait request, active low |
| bn_n | output | 1 | Bus needed, active low |

## Verification
The assertions rely on the core keeping core_req and its fields steady until core_ack. They also rely on br_n and wait_n being slow enough for the synchronizer, so that each level is held for at least two clocks. The bench changes every input only on falling edges. It keeps each request constant until it sees the acknowledge, and it lowers wait_n two cycles before an access that is meant to stall, so that the synchronized wait is already present at the strobe. Request and boundary are moved while the machine is idle, and also in the middle of an access, to show that the hand-off waits for the access to complete.

// File: rtl/ext_port_pkg.sv
`timescale 1ns/1ps
package ext_port_pkg;

    typedef enum logic [1:0] {
        SPC_PROG  = 2'd0,
        SPC_XDATA = 2'd1,
        SPC_YDATA = 2'd2,
        SPC_VECT  = 2'd3
    } space_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_STROBE,
        ST_WAIT,
        ST_FINISH,
        ST_RELEASED,
        ST_RECLAIM
    } state_e;

    // {ps_n, ds_n, xy_sel}
    typedef logic [2:0] sel_t;

    localparam sel_t SEL_IDLE = 3'b111;
    localparam sel_t SEL_X    = 3'b101;
    localparam sel_t SEL_Y    = 3'b100;
    localparam sel_t SEL_PROG = 3'b011;
    localparam sel_t SEL_VECT = 3'b010;

    function automatic sel_t space_sel(input space_e spc, input logic dev);
        sel_t s;
        unique case (spc)
            SPC_PROG:  s = SEL_PROG;
            SPC_XDATA: s = SEL_X;
            SPC_YDATA: s = SEL_Y;
            SPC_VECT:  s = dev ? SEL_VECT : SEL_PROG;
            default:   s = SEL_PROG;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/ext_port_sync.sv
`timescale 1ns/1ps
module ext_port_sync #(
    parameter int WIDTH = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] stable_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q   <= RST_VAL;
            stable_q <= RST_VAL;
        end else begin
            meta_q   <= d;
            stable_q <= meta_q;
        end
    end

    assign q = stable_q;
endmodule

// File: rtl/ext_port_seq.sv
`timescale 1ns/1ps
module ext_port_seq
    import ext_port_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          core_req,
    input  logic [1:0]    core_space,
    input  logic          core_wr,
    input  logic [AW-1:0] core_addr,
    input  logic [DW-1:0] core_wdata,
    input  logic          core_at_boundary,
    input  logic          dev_mode,
    input  logic          bus_req,
    input  logic          wait_req,
    input  logic [DW-1:0] data_i,
    output state_e        state,
    output sel_t          sel_q,
    output logic          wr_q,
    output logic [AW-1:0] addr_q,
    output logic [DW-1:0] wdata_q,
    output logic [DW-1:0] rdata_q
);
    state_e state_q, state_d;
    logic   start;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        start   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (bus_req && core_at_boundary) begin
                    state_d = ST_RELEASED;
                end else if (core_req) begin
                    state_d = ST_STROBE;
                    start   = 1'b1;
                end
            end
            ST_STROBE, ST_WAIT: state_d = wait_req ? ST_WAIT : ST_FINISH;
            ST_FINISH:          state_d = ST_IDLE;
            ST_RELEASED:        if (!bus_req) state_d = ST_RECLAIM;
            ST_RECLAIM:         state_d = ST_IDLE;
            default:            state_d = ST_IDLE;
        endcase
    end

    // Access datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q   <= SEL_IDLE;
            wr_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            if (start) begin
                sel_q   <= space_sel(space_e'(core_space), dev_mode);
                wr_q    <= core_wr;
                addr_q  <= core_addr;
                wdata_q <= core_wdata;
            end
            if (state_q == ST_FINISH && !wr_q) rdata_q <= data_i;
        end
    end

    assign state = state_q;

    // R3: address register only moves when leaving idle
    a_r3_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> $stable(addr_q));

    // R4: release only from idle at an instruction boundary
    a_r4_release_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == ST_RELEASED) |-> ($past(core_at_boundary) && $past(state_q) == ST_IDLE));
endmodule

// File: rtl/ext_port_drive.sv
`timescale 1ns/1ps
module ext_port_drive
    import ext_port_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  state_e state,
    input  sel_t   sel_q,
    input  logic   wr_q,
    output logic   ps_n,
    output logic   ds_n,
    output logic   xy_sel,
    output logic   rd_n,
    output logic   wr_n,
    output logic   bs_n,
    output logic   ctl_oe,
    output logic   addr_oe,
    output logic   data_oe,
    output logic   bg_n,
    output logic   core_ack
);
    sel_t sel;
    logic own;

    always_comb begin
        sel      = SEL_IDLE;
        rd_n     = 1'b1;
        wr_n     = 1'b1;
        bs_n     = 1'b1;
        own      = 1'b1;
        data_oe  = 1'b0;
        bg_n     = 1'b1;
        core_ack = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_STROBE, ST_WAIT: begin
                sel     = sel_q;
                rd_n    = wr_q;
                wr_n    = ~wr_q;
                bs_n    = 1'b0;
                data_oe = wr_q;
            end
            ST_FINISH: begin
                sel      = sel_q;
                rd_n     = wr_q;
                wr_n     = ~wr_q;
                data_oe  = wr_q;
                core_ack = 1'b1;
            end
            ST_RELEASED: begin
                own  = 1'b0;
                bg_n = 1'b0;
            end
            ST_RECLAIM: own = 1'b0;
            default: ;
        endcase
        if (!rst_n) begin
            own     = 1'b0;
            data_oe = 1'b0;
            bs_n    = 1'b1;
            bg_n    = 1'b1;
        end
        {ps_n, ds_n, xy_sel} = sel;
        ctl_oe  = own;
        addr_oe = own;
    end

    // R1: reserved select codes never driven
    a_r1_no_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_oe |-> (!(!ps_n && !ds_n) && !(ps_n && ds_n && !xy_sel)));

    // R10: strobes mutually exclusive
    a_r10_rw_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    // R9: data bus driven only for a write on an owned bus
    a_r9_data_oe_write: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> (!wr_n && bg_n && ctl_oe));

    // R4: granted port floats
    a_r4_grant_floats: assert property (@(posedge clk) disable iff (!rst_n)
        !bg_n |-> (!ctl_oe && !addr_oe && !data_oe));
endmodule

// File: rtl/ext_port_ctrl.sv
`timescale 1ns/1ps
module ext_port_ctrl
    import ext_port_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          core_req,
    input  logic [1:0]    core_space,
    input  logic          core_wr,
    input  logic [AW-1:0] core_addr,
    input  logic [DW-1:0] core_wdata,
    input  logic          core_at_boundary,
    input  logic          dev_mode,
    output logic          core_ack,
    output logic          core_stall,
    output logic [DW-1:0] core_rdata,
    output logic [AW-1:0] addr_o,
    output logic          addr_oe,
    output logic [DW-1:0] data_o,
    input  logic [DW-1:0] data_i,
    output logic          data_oe,
    output logic          ps_n,
    output logic          ds_n,
    output logic          xy_sel,
    output logic          rd_n,
    output logic          wr_n,
    output logic          bs_n,
    output logic          ctl_oe,
    input  logic          br_n,
    output logic          bg_n,
    input  logic          wait_n,
    output logic          bn_n
);
    localparam int SYNC_W = 2;

    logic [SYNC_W-1:0] async_in;
    logic [SYNC_W-1:0] sync_out;
    logic              bus_req_s;
    logic              wait_s;
    state_e            state;
    sel_t              sel_q;
    logic              wr_q;

    assign async_in  = {~br_n, ~wait_n};
    assign bus_req_s = sync_out[1];
    assign wait_s    = sync_out[0];

    ext_port_sync #(.WIDTH(SYNC_W), .RST_VAL('0)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (async_in),
        .q     (sync_out)
    );

    ext_port_seq #(.AW(AW), .DW(DW)) seq_i (
        .clk              (clk),
        .rst_n            (rst_n),
        .core_req         (core_req),
        .core_space       (core_space),
        .core_wr          (core_wr),
        .core_addr        (core_addr),
        .core_wdata       (core_wdata),
        .core_at_boundary (core_at_boundary),
        .dev_mode         (dev_mode),
        .bus_req          (bus_req_s),
        .wait_req         (wait_s),
        .data_i           (data_i),
        .state            (state),
        .sel_q            (sel_q),
        .wr_q             (wr_q),
        .addr_q           (addr_o),
        .wdata_q          (data_o),
        .rdata_q          (core_rdata)
    );

    ext_port_drive drive_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .state    (state),
        .sel_q    (sel_q),
        .wr_q     (wr_q),
        .ps_n     (ps_n),
        .ds_n     (ds_n),
        .xy_sel   (xy_sel),
        .rd_n     (rd_n),
        .wr_n     (wr_n),
        .bs_n     (bs_n),
        .ctl_oe   (ctl_oe),
        .addr_oe  (addr_oe),
        .data_oe  (data_oe),
        .bg_n     (bg_n),
        .core_ack (core_ack)
    );

    assign bn_n       = ~(core_req & rst_n);
    assign core_stall = core_req & ~core_ack;

    // R6: core held while another master owns the port
    a_r6_stall_unowned: assert property (@(posedge clk) disable iff (!rst_n)
        (!bg_n && core_req) |-> (core_stall && !bn_n));

    // R7: wait seen under the strobe extends the strobe
    a_r7_wait_extends: assert property (@(posedge clk) disable iff (!rst_n)
        (!bs_n && wait_s) |=> !bs_n);

    // R5: grant removed while the port still floats
    a_r5_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bg_n) |-> !ctl_oe);
endmodule

// File: tb/ext_port_ctrl_tb_top.sv
`timescale 1ns/1ps
module ext_port_ctrl_tb_top;

    typedef struct packed {
        logic [1:0]  spc;
        logic        wr;
        logic        dev;
        logic [15:0] addr;
        logic [23:0] wd;
        logic [23:0] rd;
        logic [3:0]  wt;
        logic [2:0]  sel;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 1'b0, 1'b0, 16'h0100, 24'h000000, 24'hA1B2C3, 4'd0, 3'b011},
        '{2'd1, 1'b1, 1'b0, 16'h1234, 24'h123456, 24'h000000, 4'd0, 3'b101},
        '{2'd2, 1'b0, 1'b0, 16'hFFFF, 24'h000000, 24'h00FF00, 4'd0, 3'b100},
        '{2'd3, 1'b0, 1'b1, 16'h0002, 24'h000000, 24'h0BEEF0, 4'd0, 3'b010},
        '{2'd3, 1'b0, 1'b0, 16'h0004, 24'h000000, 24'h111111, 4'd0, 3'b011},
        '{2'd1, 1'b0, 1'b0, 16'h8001, 24'h000000, 24'h7E7E7E, 4'd1, 3'b101},
        '{2'd2, 1'b1, 1'b0, 16'h4000, 24'hABCDEF, 24'h000000, 4'd3, 3'b100},
        '{2'd0, 1'b0, 1'b0, 16'h0000, 24'h000000, 24'hFFFFFF, 4'd2, 3'b011}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        core_req = 1'b0;
    logic [1:0]  core_space = 2'd0;
    logic        core_wr = 1'b0;
    logic [15:0] core_addr = '0;
    logic [23:0] core_wdata = '0;
    logic        core_at_boundary = 1'b0;
    logic        dev_mode = 1'b0;
    logic        core_ack, core_stall;
    logic [23:0] core_rdata;
    logic [15:0] addr_o;
    logic        addr_oe;
    logic [23:0] data_o;
    logic [23:0] data_i = '0;
    logic        data_oe, ps_n, ds_n, xy_sel, rd_n, wr_n, bs_n, ctl_oe;
    logic        br_n = 1'b1;
    logic        bg_n;
    logic        wait_n = 1'b1;
    logic        bn_n;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    ext_port_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .core_req(core_req), .core_space(core_space),
        .core_wr(core_wr), .core_addr(core_addr), .core_wdata(core_wdata),
        .core_at_boundary(core_at_boundary), .dev_mode(dev_mode),
        .core_ack(core_ack), .core_stall(core_stall), .core_rdata(core_rdata),
        .addr_o(addr_o), .addr_oe(addr_oe), .data_o(data_o), .data_i(data_i),
        .data_oe(data_oe), .ps_n(ps_n), .ds_n(ds_n), .xy_sel(xy_sel),
        .rd_n(rd_n), .wr_n(wr_n), .bs_n(bs_n), .ctl_oe(ctl_oe),
        .br_n(br_n), .bg_n(bg_n), .wait_n(wait_n), .bn_n(bn_n)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic run_vec(input vec_t v);
        int n;
        int exp_ack;
        if (v.wt != 0) begin
            wait_n = 1'b0;
            tick(2);
        end
        core_space = v.spc; core_wr = v.wr; dev_mode = v.dev;
        core_addr = v.addr; core_wdata = v.wd; data_i = 24'h5A5A5A;
        core_req = 1'b1;
        #1;
        check("R6 bn_n low with request", {31'd0, bn_n}, 32'd0);
        @(negedge clk);
        check("R1/R2 select code", {29'd0, ps_n, ds_n, xy_sel}, {29'd0, v.sel});
        check("R7 bs_n low first cycle", {31'd0, bs_n}, 32'd0);
        check("R10 strobes", {30'd0, rd_n, wr_n}, v.wr ? 32'd2 : 32'd1);
        check("R3 address driven", {16'd0, addr_o}, {16'd0, v.addr});
        check("R9 data_oe", {31'd0, data_oe}, {31'd0, v.wr});
        if (v.wr) check("R9 write data", {8'd0, data_o}, {8'd0, v.wd});
        exp_ack = (v.wt != 0) ? int'(v.wt) + 2 : 1;
        n = 0;
        while (n < 20) begin
            if (core_ack === 1'b1) break;
            if (n > 0) check("R7 bs_n held in wait", {31'd0, bs_n}, 32'd0);
            if (v.wt != 0 && n == int'(v.wt) - 1) wait_n = 1'b1;
            @(negedge clk);
            n++;
        end
        check("R7 access length", n, exp_ack);
        check("R7 bs_n high on last cycle", {31'd0, bs_n}, 32'd1);
        data_i = v.rd;
        core_req = 1'b0;
        @(negedge clk);
        if (!v.wr) check("R9 read data captured", {8'd0, core_rdata}, {8'd0, v.rd});
        check("R1 idle select", {29'd0, ps_n, ds_n, xy_sel}, 32'd7);
        check("R6 bn_n high when idle", {31'd0, bn_n}, 32'd1);
    endtask

    initial begin
        // R8: reset state, request held during reset
        core_req = 1'b1;
        tick(3);
        check("R8 ctl_oe in reset", {31'd0, ctl_oe}, 32'd0);
        check("R8 addr_oe in reset", {31'd0, addr_oe}, 32'd0);
        check("R8 data_oe in reset", {31'd0, data_oe}, 32'd0);
        check("R8 bg_n/bs_n/bn_n in reset", {29'd0, bg_n, bs_n, bn_n}, 32'd7);
        core_req = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 port driven after reset", {30'd0, ctl_oe, addr_oe}, 32'd3);

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R3: address holds through idle cycles
        tick(3);
        check("R3 address held idle", {16'd0, addr_o}, 32'h0000);
        run_vec(VECS[1]);
        tick(2);
        check("R3 address held idle after write", {16'd0, addr_o}, 32'h1234);

        // R4: request without boundary is not honoured
        br_n = 1'b0;
        tick(5);
        check("R4 no release without boundary", {31'd0, bg_n}, 32'd1);
        check("R4 port still driven", {31'd0, ctl_oe}, 32'd1);
        core_at_boundary = 1'b1;
        @(negedge clk);
        check("R5 grant after boundary", {31'd0, bg_n}, 32'd0);
        check("R4 port floats", {29'd0, ctl_oe, addr_oe, data_oe}, 32'd0);

        // R6: stall while unowned
        core_space = 2'd1; core_wr = 1'b0; core_addr = 16'h3333; core_req = 1'b1;
        core_at_boundary = 1'b0;
        #1;
        check("R6 bn_n while unowned", {31'd0, bn_n}, 32'd0);
        tick(3);
        check("R6 stalled while unowned", {31'd0, core_stall}, 32'd1);
        check("R6 no strobe while unowned", {30'd0, bs_n, bg_n}, 32'd2);

        // R5: give-back with turnaround cycle
        br_n = 1'b1;
        tick(2);
        check("R10 grant held two clocks", {31'd0, bg_n}, 32'd0);
        @(negedge clk);
        check("R5 grant removed", {31'd0, bg_n}, 32'd1);
        check("R5 turnaround floats", {31'd0, ctl_oe}, 32'd0);
        @(negedge clk);
        check("R5 port driven again", {31'd0, ctl_oe}, 32'd1);
        @(negedge clk);
        check("R6 pending access starts", {28'd0, bs_n, ps_n, ds_n, xy_sel}, 32'h5);
        @(negedge clk);
        check("R6 pending access completes", {31'd0, core_ack}, 32'd1);
        data_i = 24'h0C0C0C;
        core_req = 1'b0;
        @(negedge clk);
        check("R9 read after regain", {8'd0, core_rdata}, 32'h0C0C0C);

        // R4: request during an access waits for it to finish
        wait_n = 1'b0;
        tick(2);
        core_space = 2'd2; core_wr = 1'b1; core_addr = 16'h0777; core_wdata = 24'h777777;
        core_req = 1'b1; br_n = 1'b0; core_at_boundary = 1'b1;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            check("R4 no grant mid-access", {31'd0, bg_n}, 32'd1);
            if (k == 2) wait_n = 1'b1;
        end
        @(negedge clk);
        check("R4 access finished first", {31'd0, core_ack}, 32'd1);
        core_req = 1'b0;
        @(negedge clk);
        check("R4 idle before release", {31'd0, bg_n}, 32'd1);
        @(negedge clk);
        check("R4 release after access", {31'd0, bg_n}, 32'd0);
        br_n = 1'b1; core_at_boundary = 1'b0;
        tick(4);
        check("R5 port back after hand-off", {30'd0, bg_n, ctl_oe}, 32'd3);
        check("R3 address held over hand-off", {16'd0, addr_o}, 32'h0777);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #400000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule